// File: doc/BRIEF.md
# Usage-Counter Way Replacement Selector

This block holds the replacement decision logic for a single set of an N-way set-associative cache. Each way owns a small saturating usage counter, kept in external storage. The cache controller reads the set's counter vector and presents it to the block with an operation code and, where relevant, a way index. The block returns the way to evict and the counter vector that the controller writes back. Tag comparison and the storage arrays stay in the controller.

The number of usage states U (2, 3 or 4) is a runtime setting. The highest counter value is U-1. A hit promotes the way that was hit and ages only the ways ranked above it. A miss first picks a victim, then ages every way whose counter is nonzero, and then promotes the victim. An invalidate drops one way to the lowest rank. The block is not true LRU: ties go to the lowest way index, and hits and misses age the counters by different rules.

The logic is combinational from the counter vector to the results. A parameter can add one output register stage.

Top module: `usage_repl_sel`

## Requirements
- R1: After reset U is 2, so the highest counter value is 1. A write of 2, 3 or 4 through `cfg_we`/`cfg_states` sets U, and U applies to operations from the next clock cycle on.
- R2: A configuration write with a value outside 2..4 is ignored, and the previous U stays in effect.
- R3: On a hit (op code 2'b01), the counter of way `way_idx` becomes U-1.
- R4: On a hit, every other way whose counter is strictly greater than the hit way's old counter decrements by one. All remaining ways keep their value.
- R5: `victim` scans the ways in ascending order, starting from a running minimum of U-1, and takes the first way whose counter is strictly below the running minimum. When no way is below U-1 it is way 0. `victim` shows this choice for every op code.
- R6: On a miss (op code 2'b10), every way other than the victim that has a nonzero counter decrements by one, and the victim's counter becomes U-1.
- R7: On an invalidate (op code 2'b11), the counter of way `way_idx` becomes 0 and all other counters stay unchanged.
- R8: On idle (op code 2'b00), `cnt_out` equals `cnt_in`. Way i's counter is at bits [2i+1:2i] of both vectors.
- R9: With `REG_OUT`=1, `victim`, `cnt_out` and `out_valid` show the result of the inputs one clock cycle later, and they are 0 during reset. With `REG_OUT`=0 they follow the inputs in the same cycle. `out_valid` is 1 for any op code other than idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the usage-state setting |
| cfg_states | input | 3 | Requested number of usage states |
| op | input | 2 | Operation: 00 idle, 01 hit, 10 miss, 11 invalidate |
| way_idx | input | WIW | Way that was hit or is being invalidated |
| cnt_in | input | 2*WAYS | Counter vector read from storage |
| victim | output | WIW | Way chosen for replacement |
| cnt_out | output | 2*WAYS | Updated counter vector for write-back |
| out_valid | output | 1 | Result belongs to a non-idle operation |

## Verification
The block holds no state apart from U, so most faults show up at once: a wrong ageing rule or victim scan corrupts `cnt_out` or `victim` on the same operation, or one cycle later when the output register is present. A wrong U shows only in the promoted value and in where the victim scan starts. For this reason each setting is exercised with hits and misses right after it is written, and again after rejected writes. A corrupted counter would only affect later decisions after the controller writes it back. For this reason every counter vector of a 4-way set is swept under each op code and each U, instead of relying on sequences of operations.

// File: rtl/usage_repl_pkg.sv
package usage_repl_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_HIT   = 2'b01,
    OP_MISS  = 2'b10,
    OP_INVAL = 2'b11
  } repl_op_e;

  localparam int CNT_W      = 2;
  localparam int MIN_STATES = 2;
  localparam int MAX_STATES = 4;

  // a state count is accepted only inside the supported range
  function automatic logic states_legal(input logic [2:0] n);
    return (n >= 3'(MIN_STATES)) && (n <= 3'(MAX_STATES));
  endfunction

  // highest counter value for a legal state count
  function automatic logic [CNT_W-1:0] states_to_top(input logic [2:0] n);
    logic [2:0] t;
    t = n - 3'd1;
    return t[CNT_W-1:0];
  endfunction

  // one step of ageing, stopping at zero
  function automatic logic [CNT_W-1:0] age_once(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

endpackage

// File: rtl/urs_cfg.sv
module urs_cfg
  import usage_repl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_states,
  output logic [CNT_W-1:0] u_top
);

  logic take_cfg;

  assign take_cfg = cfg_we && states_legal(cfg_states);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_top <= states_to_top(3'(MIN_STATES));
    end else if (take_cfg) begin
      u_top <= states_to_top(cfg_states);
    end
  end

endmodule

// File: rtl/urs_victim.sv
module urs_victim
  import usage_repl_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int WIW  = 2
) (
  input  logic [CNT_W*WAYS-1:0] cnt,
  input  logic [CNT_W-1:0]      top,
  output logic [WIW-1:0]        vic
);

  logic [CNT_W-1:0] fld [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_unpack
    assign fld[g] = cnt[g*CNT_W +: CNT_W];
  end

  // ascending scan; a strict compare keeps the lowest index on ties
  always_comb begin
    logic [CNT_W-1:0] run_min;
    run_min = top;
    vic     = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (fld[i] < run_min) begin
        run_min = fld[i];
        vic     = WIW'(i);
      end
    end
  end

endmodule

// File: rtl/urs_update.sv
module urs_update
  import usage_repl_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int WIW  = 2
) (
  input  logic [CNT_W*WAYS-1:0] cnt,
  input  repl_op_e              op,
  input  logic [WIW-1:0]        way,
  input  logic [WIW-1:0]        vic,
  input  logic [CNT_W-1:0]      top,
  output logic [CNT_W*WAYS-1:0] nxt
);

  logic [CNT_W-1:0] fld [WAYS];
  logic [CNT_W-1:0] hit_old;

  for (genvar g = 0; g < WAYS; g++) begin : g_unpack
    assign fld[g] = cnt[g*CNT_W +: CNT_W];
  end

  // old counter of the addressed way, by selection over all ways
  always_comb begin
    hit_old = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (WIW'(i) == way) hit_old = fld[i];
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic self_w;
    logic self_v;
    assign self_w = (WIW'(g) == way);
    assign self_v = (WIW'(g) == vic);

    always_comb begin
      unique case (op)
        OP_HIT: begin
          if (self_w)              nxt[g*CNT_W +: CNT_W] = top;
          else if (fld[g] > hit_old) nxt[g*CNT_W +: CNT_W] = fld[g] - 1'b1;
          else                     nxt[g*CNT_W +: CNT_W] = fld[g];
        end
        OP_MISS: begin
          if (self_v) nxt[g*CNT_W +: CNT_W] = top;
          else        nxt[g*CNT_W +: CNT_W] = age_once(fld[g]);
        end
        OP_INVAL: begin
          nxt[g*CNT_W +: CNT_W] = self_w ? '0 : fld[g];
        end
        default: begin
          nxt[g*CNT_W +: CNT_W] = fld[g];
        end
      endcase
    end
  end

endmodule

// File: rtl/urs_outreg.sv
module urs_outreg #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end else begin : g_wire
    assign q = d;
  end

endmodule

// File: rtl/usage_repl_sel.sv
module usage_repl_sel
  import usage_repl_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter bit REG_OUT = 1'b1,
  parameter int WIW     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_states,
  input  logic [1:0]            op,
  input  logic [WIW-1:0]        way_idx,
  input  logic [CNT_W*WAYS-1:0] cnt_in,
  output logic [WIW-1:0]        victim,
  output logic [CNT_W*WAYS-1:0] cnt_out,
  output logic                  out_valid
);

  localparam int VW  = CNT_W * WAYS;
  localparam int OUT = 1 + WIW + VW;

  repl_op_e         op_e;
  logic [CNT_W-1:0] u_top;
  logic [WIW-1:0]   vic_w;
  logic [VW-1:0]    nxt_cnt;
  logic             hit_evt;
  logic             miss_evt;
  logic             inv_evt;
  logic             any_evt;
  logic [OUT-1:0]   res_d;
  logic [OUT-1:0]   res_q;

  assign op_e     = repl_op_e'(op);
  assign hit_evt  = (op_e == OP_HIT);
  assign miss_evt = (op_e == OP_MISS);
  assign inv_evt  = (op_e == OP_INVAL);
  assign any_evt  = hit_evt || miss_evt || inv_evt;

  urs_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_states (cfg_states),
    .u_top      (u_top)
  );

  urs_victim #(.WAYS(WAYS), .WIW(WIW)) u_vic (
    .cnt (cnt_in),
    .top (u_top),
    .vic (vic_w)
  );

  urs_update #(.WAYS(WAYS), .WIW(WIW)) u_upd (
    .cnt (cnt_in),
    .op  (op_e),
    .way (way_idx),
    .vic (vic_w),
    .top (u_top),
    .nxt (nxt_cnt)
  );

  assign res_d = {any_evt, vic_w, nxt_cnt};

  urs_outreg #(.W(OUT), .REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (res_d),
    .q     (res_q)
  );

  assign out_valid = res_q[OUT-1];
  assign victim    = res_q[VW +: WIW];
  assign cnt_out   = res_q[VW-1:0];

endmodule

// File: rtl/usage_repl_sel_chk.sv
module usage_repl_sel_chk
  import usage_repl_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter bit REG_OUT = 1'b1,
  parameter int WIW     = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic [2:0]            cfg_states,
  input logic [WIW-1:0]        way_idx,
  input logic [CNT_W*WAYS-1:0] cnt_in,
  input logic [CNT_W-1:0]      u_top,
  input logic                  hit_evt,
  input logic                  miss_evt,
  input logic                  inv_evt,
  input logic [WIW-1:0]        vic_w,
  input logic [CNT_W*WAYS-1:0] nxt_cnt,
  input logic [CNT_W*WAYS-1:0] cnt_out,
  input logic [WIW-1:0]        victim,
  input logic                  out_valid
);

  function automatic logic [CNT_W-1:0] pick(input logic [CNT_W*WAYS-1:0] v,
                                            input logic [WIW-1:0] w);
    logic [CNT_W-1:0] r;
    r = '0;
    for (int i = 0; i < WAYS; i++) if (WIW'(i) == w) r = v[i*CNT_W +: CNT_W];
    return r;
  endfunction

  function automatic logic others_not_raised(input logic [CNT_W*WAYS-1:0] a,
                                             input logic [CNT_W*WAYS-1:0] b,
                                             input logic [WIW-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < WAYS; i++)
      if (WIW'(i) != w && a[i*CNT_W +: CNT_W] > b[i*CNT_W +: CNT_W]) ok = 1'b0;
    return ok;
  endfunction

  a_r1_top_range: assert property (@(posedge clk) disable iff (!rst_n)
    (u_top >= 2'd1) && (u_top <= 2'd3));

  a_r2_bad_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !states_legal(cfg_states)) |=> $stable(u_top));

  a_r3_hit_promote: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> (pick(nxt_cnt, way_idx) == u_top));

  a_r4_hit_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> others_not_raised(nxt_cnt, cnt_in, way_idx));

  a_r5_victim_low: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |-> ((vic_w == '0) || (pick(cnt_in, vic_w) < u_top)));

  a_r6_miss_promote: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |-> (pick(nxt_cnt, vic_w) == u_top));

  a_r7_inval_zero: assert property (@(posedge clk) disable iff (!rst_n)
    inv_evt |-> (pick(nxt_cnt, way_idx) == '0));

  if (REG_OUT) begin : g_lat
    a_r9_out_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_evt || miss_evt || inv_evt) |=> (out_valid && cnt_out == $past(nxt_cnt)
                                            && victim == $past(vic_w)));
  end else begin : g_comb
    a_r9_out_same: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_out == nxt_cnt) && (victim == vic_w));
  end

endmodule

bind usage_repl_sel usage_repl_sel_chk #(.WAYS(WAYS), .REG_OUT(REG_OUT), .WIW(WIW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_states (cfg_states),
  .way_idx    (way_idx),
  .cnt_in     (cnt_in),
  .u_top      (u_top),
  .hit_evt    (hit_evt),
  .miss_evt   (miss_evt),
  .inv_evt    (inv_evt),
  .vic_w      (vic_w),
  .nxt_cnt    (nxt_cnt),
  .cnt_out    (cnt_out),
  .victim     (victim),
  .out_valid  (out_valid)
);

// File: tb/usage_repl_sel_tb.sv
`timescale 1ns/1ps
module usage_repl_sel_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_states = 3'd0;
  logic [1:0]  r_op = 2'b00;
  logic [2:0]  r_w = 3'd0;
  logic [15:0] r_cnt = 16'd0;

  int n_chk = 0;
  int n_bad = 0;
  int cur_top = 1;

  logic [1:0]  c1;  logic       v1;  logic o1;
  logic [3:0]  c2;  logic       v2;  logic o2;
  logic [7:0]  c4;  logic [1:0] v4;  logic o4;
  logic [15:0] c8;  logic [2:0] v8;  logic o8;
  logic [7:0]  c4z; logic [1:0] v4z; logic o4z;

  usage_repl_sel #(.WAYS(1), .REG_OUT(1'b1)) u_dut_w1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_states(cfg_states), .op(r_op),
    .way_idx(1'b0), .cnt_in(r_cnt[1:0]), .victim(v1), .cnt_out(c1), .out_valid(o1));
  usage_repl_sel #(.WAYS(2), .REG_OUT(1'b1)) u_dut_w2 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_states(cfg_states), .op(r_op),
    .way_idx(r_w[0]), .cnt_in(r_cnt[3:0]), .victim(v2), .cnt_out(c2), .out_valid(o2));
  usage_repl_sel #(.WAYS(4), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_states(cfg_states), .op(r_op),
    .way_idx(r_w[1:0]), .cnt_in(r_cnt[7:0]), .victim(v4), .cnt_out(c4), .out_valid(o4));
  usage_repl_sel #(.WAYS(8), .REG_OUT(1'b1)) u_dut_w8 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_states(cfg_states), .op(r_op),
    .way_idx(r_w), .cnt_in(r_cnt), .victim(v8), .cnt_out(c8), .out_valid(o8));
  usage_repl_sel #(.WAYS(4), .REG_OUT(1'b0)) u_dut_comb (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_states(cfg_states), .op(r_op),
    .way_idx(r_w[1:0]), .cnt_in(r_cnt[7:0]), .victim(v4z), .cnt_out(c4z), .out_valid(o4z));

  // expected victim: the global minimum below the top value, lowest index first
  function automatic int exp_vic(input logic [15:0] c, input int n, input int top);
    int mn;
    mn = 3;
    for (int i = 0; i < n; i++) if (int'(c[2*i +: 2]) < mn) mn = int'(c[2*i +: 2]);
    if (mn >= top) return 0;
    for (int i = 0; i < n; i++) if (int'(c[2*i +: 2]) == mn) return i;
    return 0;
  endfunction

  function automatic logic [15:0] exp_cnt(input logic [15:0] c, input int n, input int op,
                                          input int w, input int top);
    logic [15:0] r;
    int f, hv, vv;
    r  = '0;
    hv = int'(c[2*w +: 2]);
    vv = exp_vic(c, n, top);
    for (int i = 0; i < n; i++) begin
      f = int'(c[2*i +: 2]);
      case (op)
        1: f = (i == w) ? top : ((f > hv) ? f - 1 : f);
        2: f = (i == vv) ? top : ((f > 0) ? f - 1 : 0);
        3: f = (i == w) ? 0 : f;
        default: f = f;
      endcase
      r[2*i +: 2] = 2'(f);
    end
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string op_req(input int op);
    case (op)
      1: return "R4 hit ageing";
      2: return "R6 miss ageing";
      3: return "R7 invalidate";
      default: return "R8 idle pass";
    endcase
  endfunction

  task automatic chk_one(input string nm, input int n, input logic [15:0] ac, input int av,
                         input logic ao);
    int w;
    w = int'(r_w) & (n - 1);
    chk({op_req(int'(r_op)), " ", nm}, int'(ac), int'(exp_cnt(r_cnt, n, int'(r_op), w, cur_top)));
    chk({"R5 victim ", nm}, av, exp_vic(r_cnt, n, cur_top));
    chk({"R9 valid ", nm}, int'(ao), int'(r_op != 2'b00));
  endtask

  // inputs change at a falling edge; comb result checked 2 ns later,
  // registered results at the next falling edge
  task automatic step(input logic [1:0] op, input logic [2:0] w, input logic [15:0] cv);
    r_op = op; r_w = w; r_cnt = cv;
    #2;
    chk_one("comb", 4, {8'd0, c4z}, int'(v4z), o4z);
    @(negedge clk);
    chk_one("w1", 1, {14'd0, c1}, int'(v1), o1);
    chk_one("w2", 2, {12'd0, c2}, int'(v2), o2);
    chk_one("w4", 4, {8'd0, c4}, int'(v4), o4);
    chk_one("w8", 8, c8, int'(v8), o8);
  endtask

  task automatic set_states(input logic [2:0] n);
    cfg_we = 1'b1; cfg_states = n;
    @(negedge clk);
    cfg_we = 1'b0;
    if (n >= 3'd2 && n <= 3'd4) cur_top = int'(n) - 1;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: registered outputs are clear during reset
    chk("R9 reset cnt_out", int'(c8), 0);
    chk("R9 reset out_valid", int'(o8), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default U is 2, so a hit promotes to 1
    step(2'b01, 3'd2, 16'h0000);
    chk("R1 default top", int'(c4[5:4]), 1);
    // R1: a legal write takes effect on the next operation
    set_states(3'd4);
    step(2'b01, 3'd1, 16'h0000);
    chk("R3 hit promote top 3", int'(c4[3:2]), 3);
    // R2: illegal writes leave U at 4
    set_states(3'd5);
    set_states(3'd1);
    set_states(3'd0);
    set_states(3'd7);
    step(2'b01, 3'd0, 16'h0000);
    chk("R2 illegal cfg ignored", int'(c4[1:0]), 3);
    step(2'b10, 3'd0, 16'h00FF);
    chk("R2 miss still uses top 3", int'(v4), 0);
    // sweep every 4-way counter vector under each op and each U
    for (int u = 2; u <= 4; u++) begin
      set_states(3'(u));
      for (int v = 0; v < 256; v++) begin
        for (int op = 0; op < 4; op++) begin
          step(2'(op), 3'((v + op * 3) & 7), {8'(v ^ 8'h5A), 8'(v)});
        end
      end
    end
    step(2'b00, 3'd0, 16'h0000);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule